// File: doc/BRIEF.md
# Floating-Point Compare Condition-Code Writer

This block sits behind a floating-point comparator. The comparator gives one of four relation results: less, equal, greater or unordered. On each valid strobe the block takes that result and the current 64-bit floating-point status word. It writes a 2-bit condition code into one of four condition-code fields, chosen by a selector. The new status word and a one-cycle trap request appear on the clock edge after the strobe. The comparison of the operands themselves is done elsewhere.

An unordered result also needs an invalid-operation response. A trap is raised when the compare is the signalling variant, or when the invalid-trap enable bit of the incoming status word is set. A trapping result records the current invalid flag and the IEEE-exception trap type. A non-trapping unordered result sets only the accrued invalid flag. Ordered results change nothing except the selected field.

Internally a small outcome machine registers what the last strobe produced. It has four states:
- OUT_IDLE: no strobe in the previous cycle.
- OUT_ORDERED: less, equal or greater.
- OUT_ACCRUE: unordered without a trap.
- OUT_TRAP: unordered with a trap.

Transitions:
- Every cycle with a strobe moves the machine from any state to the outcome of that strobe.
- Every cycle without a strobe returns it to OUT_IDLE.

The trap request is decoded from OUT_TRAP.

Top module: `fpcc_writer`

## Requirements
- R1: While reset is asserted and after its release, before any strobe, `status_out` is all zero and `trap_req` is 0.
- R2: The relation input is encoded as follows: 0 less, 1 equal, 2 greater, 3 unordered. The code written into the selected field is 01 for less, 00 for equal, 10 for greater and 11 for unordered. The field is cleared before the code is written. The new value shows on `status_out` one clock edge after the strobe.
- R3: Field selector 0 puts the code in bits 11:10. Selectors 1, 2 and 3 put it in bits 33:32, 35:34 and 37:36 respectively.
- R4: For less, equal and greater, every bit outside the selected field equals the incoming status bit, and `trap_req` stays 0.
- R5: An unordered result with `signalling_in` = 1 raises a trap, whatever the value of bit 27.
- R6: An unordered result with `signalling_in` = 0 raises a trap when bit 27 (invalid-trap enable) of the incoming status word is 1.
- R7: On a trap, the selected field becomes 11, and bit 4 (current invalid) and bit 14 (trap type IEEE exception) are set. All other bits pass through unchanged. `trap_req` is 1 for exactly the one cycle after the strobe.
- R8: An unordered result that does not trap sets bit 9 (accrued invalid) and writes 11 into the selected field. All other bits pass through, and `trap_req` stays 0.
- R9: In a cycle without a strobe, `status_out` keeps its value whatever the other inputs do, and `trap_req` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | Compare result strobe |
| relation_in | input | 2 | Relation: 0 less, 1 equal, 2 greater, 3 unordered |
| field_sel_in | input | 2 | Condition-code field selector |
| signalling_in | input | 1 | Compare is the signalling variant |
| status_in | input | 64 | Current status word |
| status_out | output | 64 | Updated status word, registered |
| trap_req | output | 1 | One-cycle trap request |

## Verification
The assertions assume that every input is at a known value at each rising edge once reset is released. They also assume that the status word presented with a strobe is the one to be updated; no relation to earlier outputs is expected. The stimulus drives all inputs on the falling edge and never leaves them undriven. It draws relation, selector, signalling flag and status word from a seeded generator. The enable bit is forced both ways, so that every outcome state and both trap causes occur. Idle cycles with changing inputs are mixed in.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;

    typedef enum logic [1:0] {
        REL_LESS    = 2'd0,
        REL_EQUAL   = 2'd1,
        REL_GREATER = 2'd2,
        REL_UNORD   = 2'd3
    } rel_e;

    typedef enum logic [1:0] {
        OUT_IDLE    = 2'd0,
        OUT_ORDERED = 2'd1,
        OUT_ACCRUE  = 2'd2,
        OUT_TRAP    = 2'd3
    } outcome_e;

    localparam int NUM_FIELDS = 4;

    // Bit offset of condition-code field idx.
    function automatic int field_offset(input int idx, input int base,
                                        input int upper_shift, input int stride);
        if (idx == 0) return base;
        return base + upper_shift + (idx - 1) * stride;
    endfunction

endpackage

// File: rtl/fpcc_code_map.sv
module fpcc_code_map
    import fpcc_pkg::*;
(
    input  rel_e       rel,
    output logic [1:0] code,
    output logic       is_unord
);
    always_comb begin
        code     = 2'b00;
        is_unord = 1'b0;
        unique case (rel)
            REL_LESS:    code = 2'b01;
            REL_EQUAL:   code = 2'b00;
            REL_GREATER: code = 2'b10;
            REL_UNORD: begin
                code     = 2'b11;
                is_unord = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/fpcc_field_merge.sv
module fpcc_field_merge
    import fpcc_pkg::*;
#(
    parameter int W           = 64,
    parameter int BASE        = 10,
    parameter int UPPER_SHIFT = 22,
    parameter int STRIDE      = 2,
    localparam int SEL_W      = $clog2(NUM_FIELDS)
) (
    input  logic [W-1:0]     cur,
    input  logic [SEL_W-1:0] sel,
    input  logic [1:0]       code,
    output logic [W-1:0]     merged
);
    logic [W-1:0] clear_mask [NUM_FIELDS];
    logic [W-1:0] code_bits  [NUM_FIELDS];

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        localparam int OFS = field_offset(g, BASE, UPPER_SHIFT, STRIDE);
        assign clear_mask[g] = {{(W-2){1'b0}}, 2'b11} << OFS;
        assign code_bits[g]  = {{(W-2){1'b0}}, code}  << OFS;
    end

    always_comb begin
        merged = (cur & ~clear_mask[sel]) | code_bits[sel];
    end
endmodule

// File: rtl/fpcc_unord_policy.sv
module fpcc_unord_policy
    import fpcc_pkg::*;
(
    input  logic     valid,
    input  logic     is_unord,
    input  logic     signalling,
    input  logic     trap_enable,
    output outcome_e outcome
);
    always_comb begin
        if (!valid)                          outcome = OUT_IDLE;
        else if (!is_unord)                  outcome = OUT_ORDERED;
        else if (signalling || trap_enable)  outcome = OUT_TRAP;
        else                                 outcome = OUT_ACCRUE;
    end
endmodule

// File: rtl/fpcc_writer.sv
module fpcc_writer
    import fpcc_pkg::*;
#(
    parameter int STATUS_W    = 64,
    parameter int CC_BASE     = 10,
    parameter int UPPER_SHIFT = 22,
    parameter int UPPER_STEP  = 2,
    parameter int TEN_NV_BIT  = 27,
    parameter int CUR_NV_BIT  = 4,
    parameter int ACC_NV_BIT  = 9,
    parameter int FTT_IEEE_BIT = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid_in,
    input  logic [1:0]          relation_in,
    input  logic [1:0]          field_sel_in,
    input  logic                signalling_in,
    input  logic [STATUS_W-1:0] status_in,
    output logic [STATUS_W-1:0] status_out,
    output logic                trap_req
);
    localparam int TOP_BIT = field_offset(NUM_FIELDS-1, CC_BASE, UPPER_SHIFT, UPPER_STEP) + 1;
    localparam logic [STATUS_W-1:0] CUR_NV_M = {{(STATUS_W-1){1'b0}}, 1'b1} << CUR_NV_BIT;
    localparam logic [STATUS_W-1:0] ACC_NV_M = {{(STATUS_W-1){1'b0}}, 1'b1} << ACC_NV_BIT;
    localparam logic [STATUS_W-1:0] FTT_M    = {{(STATUS_W-1){1'b0}}, 1'b1} << FTT_IEEE_BIT;

    logic [1:0]          code;
    logic                is_unord;
    logic [STATUS_W-1:0] merged;
    logic [STATUS_W-1:0] status_nxt;
    outcome_e            outcome_nxt;
    outcome_e            out_state;
    logic [STATUS_W-1:0] status_q;

    fpcc_code_map u_map (
        .rel      (rel_e'(relation_in)),
        .code     (code),
        .is_unord (is_unord)
    );

    fpcc_field_merge #(
        .W           (STATUS_W),
        .BASE        (CC_BASE),
        .UPPER_SHIFT (UPPER_SHIFT),
        .STRIDE      (UPPER_STEP)
    ) u_merge (
        .cur    (status_in),
        .sel    (field_sel_in),
        .code   (code),
        .merged (merged)
    );

    fpcc_unord_policy u_policy (
        .valid       (valid_in),
        .is_unord    (is_unord),
        .signalling  (signalling_in),
        .trap_enable (status_in[TEN_NV_BIT]),
        .outcome     (outcome_nxt)
    );

    // Status word for each outcome.
    always_comb begin
        status_nxt = status_q;
        unique case (outcome_nxt)
            OUT_IDLE:    status_nxt = status_q;
            OUT_ORDERED: status_nxt = merged;
            OUT_ACCRUE:  status_nxt = merged | ACC_NV_M;
            OUT_TRAP:    status_nxt = merged | CUR_NV_M | FTT_M;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_state <= OUT_IDLE;
            status_q  <= '0;
        end else begin
            out_state <= outcome_nxt;
            status_q  <= status_nxt;
        end
    end

    // Outputs.
    always_comb begin
        status_out = status_q;
        trap_req   = 1'b0;
        unique case (out_state)
            OUT_IDLE, OUT_ORDERED, OUT_ACCRUE: trap_req = 1'b0;
            OUT_TRAP:                          trap_req = 1'b1;
        endcase
    end

    initial begin
        if (TOP_BIT >= STATUS_W)
            $error("condition-code field beyond status width");
    end

    // R5
    a_r5_signalling_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && relation_in == 2'd3 && signalling_in) |=> trap_req);

    // R6
    a_r6_enable_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && relation_in == 2'd3 && status_in[TEN_NV_BIT]) |=> trap_req);

    // R7
    a_r7_trap_marks: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (status_out[CUR_NV_BIT] && status_out[FTT_IEEE_BIT]));

    // R8
    a_r8_accrue: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && relation_in == 2'd3 && !signalling_in && !status_in[TEN_NV_BIT])
        |=> (!trap_req && status_out[ACC_NV_BIT]));

    // R4
    a_r4_ordered_no_exc: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && relation_in != 2'd3)
        |=> (!trap_req
             && status_out[ACC_NV_BIT] == $past(status_in[ACC_NV_BIT])
             && status_out[CUR_NV_BIT] == $past(status_in[CUR_NV_BIT])));

    // R3
    a_r3_field1_less: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && relation_in == 2'd0 && field_sel_in == 2'd1)
        |=> status_out[CC_BASE+UPPER_SHIFT +: 2] == 2'b01);

    // R9
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> ($stable(status_out) && !trap_req));
endmodule

// File: tb/fpcc_writer_tb_top.sv
`timescale 1ns/1ps
module fpcc_writer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [1:0]  relation_in = 2'd0;
    logic [1:0]  field_sel_in = 2'd0;
    logic        signalling_in = 1'b0;
    logic [63:0] status_in = '0;
    logic [63:0] status_out;
    logic        trap_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fpcc_writer dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .valid_in      (valid_in),
        .relation_in   (relation_in),
        .field_sel_in  (field_sel_in),
        .signalling_in (signalling_in),
        .status_in     (status_in),
        .status_out    (status_out),
        .trap_req      (trap_req)
    );

    function automatic int offs(input logic [1:0] sel);
        return (sel == 2'd0) ? 10 : 32 + 2 * (int'(sel) - 1);
    endfunction

    // Returns {trap, new status}.
    function automatic logic [64:0] model(input logic [63:0] cur, input logic [1:0] rel,
                                          input logic [1:0] sel, input logic sig);
        logic [63:0] s;
        logic [1:0]  c;
        logic        t;
        c = (rel == 2'd0) ? 2'b01 : (rel == 2'd2) ? 2'b10 : (rel == 2'd3) ? 2'b11 : 2'b00;
        s = cur & ~(64'h3 << offs(sel));
        s = s | (64'(c) << offs(sel));
        t = 1'b0;
        if (rel == 2'd3) begin
            if (sig || cur[27]) begin
                t = 1'b1;
                s = s | (64'h1 << 4) | (64'h1 << 14);
            end else begin
                s = s | (64'h1 << 9);
            end
        end
        return {t, s};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the result.
    task automatic apply(input string req, input logic [63:0] cur, input logic [1:0] rel,
                         input logic [1:0] sel, input logic sig);
        logic [64:0] e;
        e = model(cur, rel, sel, sig);
        valid_in = 1'b1; status_in = cur; relation_in = rel;
        field_sel_in = sel; signalling_in = sig;
        @(posedge clk); @(negedge clk);
        valid_in = 1'b0;
        chk(req, status_out, e[63:0]);
        chk(req, {63'd0, trap_req}, {63'd0, e[64]});
    endtask

    // R9 and single-cycle trap pulse of R7.
    task automatic idle_check();
        logic [63:0] held;
        held = status_out;
        valid_in = 1'b0;
        status_in = {$urandom, $urandom};
        relation_in = 2'($urandom);
        signalling_in = 1'($urandom);
        @(posedge clk); @(negedge clk);
        chk("R9 hold", status_out, held);
        chk("R9,R7 no trap when idle", {63'd0, trap_req}, 64'd0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        chk("R1 reset status", status_out, 64'd0);
        chk("R1 reset trap", {63'd0, trap_req}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", status_out, 64'd0);

        // Directed: each code in each field (R2, R3).
        for (int s = 0; s < 4; s++) begin
            for (int r = 0; r < 3; r++) begin
                apply("R2,R3 code in field", 64'hFFFF_FFFF_F7FF_FDEF, 2'(r), 2'(s), 1'b0);
            end
        end
        // Ordered with all-ones background (R4).
        apply("R4 passthrough", 64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 2'd2, 1'b1);
        apply("R4 passthrough", 64'h0, 2'd2, 2'd3, 1'b1);
        // Trap causes.
        apply("R5 signalling trap", 64'h0, 2'd3, 2'd0, 1'b1);
        idle_check();
        apply("R6 enable trap", 64'h0000_0000_0800_0000, 2'd3, 2'd1, 1'b0);
        apply("R7 back-to-back trap", 64'h0000_0000_0800_0000, 2'd3, 2'd3, 1'b1);
        idle_check();
        apply("R8 accrue", 64'h0, 2'd3, 2'd2, 1'b0);
        idle_check();

        for (int i = 0; i < 400; i++) begin
            logic [63:0] cur;
            logic [1:0]  rel;
            string       tag;
            cur = {$urandom, $urandom};
            rel = 2'($urandom);
            if ($urandom % 3 == 0) cur[27] = 1'b0;
            if (rel != 2'd3) tag = "R2,R4 random";
            else tag = "R5,R6,R7,R8 random unordered";
            apply(tag, cur, rel, 2'($urandom), 1'($urandom % 4 == 0));
            if ($urandom % 5 == 0) idle_check();
        end

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule